// File: doc/BRIEF.md
# Byte-Serial Accumulator ALU

This block is the arithmetic core of a small byte-wide processor that still handles 16-bit words. It holds a word in a two-byte accumulator and works on it one byte at a time, with a single byte-wide adder. On every step strobe it combines the byte on the data input with the lowest accumulator byte, as the function code selects. The result enters the top accumulator byte, and every other byte moves down one place. After one step per byte, with the low byte first, the whole word result is back in its correct place.

Six functions are available: load, add, bit clear, bit set, shift right and shift left. Bit clear and bit set pass through the same adder as the arithmetic functions. The adder inputs are masked so that no bit position ever has both operands set, which makes the adder act as plain OR gates. A held carry flag links the two byte cycles of a word add. A held shift-in flag feeds the top bit of a right shift. A start-of-word flag given with the first step clears both flags for that step. Subtract, exclusive-or and invert are left to the sequencing microcode.

Top module: `bsalu`

## Requirements
- R1: After reset, acc_o reads 0x0000 and carry_o reads 0.
- R2: In a cycle with step_i low, acc_o and carry_o keep their values, whatever func_i, data_i and sow_i are.
- R3: On a step, the byte result is written to the top accumulator byte (acc_o[15:8]). Each lower byte takes the old value of the byte above it, so acc_o[7:0] receives the old acc_o[15:8]. The result appears at acc_o one clock after the step.
- R4: Function code 0 (load) gives the data byte as result, and clears carry_o.
- R5: Function code 1 (add) gives data_i + acc_o[7:0] + carry-in. The carry-in is the carry flag left by the previous step. carry_o takes the carry out of bit 7.
- R6: Function code 5 (shift left) behaves exactly like code 1.
- R7: Function code 2 (bit clear) gives data_i AND NOT acc_o[7:0], and clears carry_o.
- R8: Function code 3 (bit set) gives data_i OR acc_o[7:0], and clears carry_o.
- R9: Function code 4 (shift right) gives {shift-in, acc_o[7:1]} + data_i, and carry_o takes the carry out. The shift-in flag is acc_o[7:0] bit 0 as it stood at the previous step, if that step used code 4. Otherwise the shift-in flag is 0.
- R10: Function codes 6 and 7 behave exactly like code 0.
- R11: A step with sow_i high uses a carry-in of 0 and a shift-in of 0, whatever the held flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Perform one byte cycle |
| sow_i | input | 1 | First byte of a word: clears carry-in and shift-in |
| func_i | input | 3 | Function code |
| data_i | input | 8 | Data bus byte |
| acc_o | output | 16 | Accumulator word {AH, AL} |
| carry_o | output | 1 | Held carry flag |

## Verification
A wrong carry flag is hidden at first. It shows in carry_o one clock after a step, and it corrupts the top byte only on the next add or shift-left step that does not raise sow_i. A wrong shift-in flag stays invisible until a second, unflagged shift-right step sets or clears bit 15. A rotation fault shows in acc_o[7:0] one clock after any step. The reference model is compared on every clock, so each of these faults is caught in the first cycle it reaches a port.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;
    localparam int FUNC_W = 3;

    typedef enum logic [FUNC_W-1:0] {
        FN_LOAD = 3'd0,
        FN_ADD  = 3'd1,
        FN_BIC  = 3'd2,
        FN_BIS  = 3'd3,
        FN_SHR  = 3'd4,
        FN_SHL  = 3'd5
    } alu_fn_e;
endpackage

// File: rtl/bsalu_opgate.sv
module bsalu_opgate
    import bsalu_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [FUNC_W-1:0] func_i,
    input  logic [BYTE_W-1:0] low_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              cflag_i,
    input  logic              sflag_i,
    input  logic              sow_i,
    output logic [BYTE_W-1:0] a_op_o,
    output logic [BYTE_W-1:0] b_op_o,
    output logic              cin_o,
    output logic              sflag_nxt_o
);
    logic              carry_eff;
    logic              shin_eff;
    logic [BYTE_W-1:0] masked;
    logic [BYTE_W-1:0] low_shr;

    always_comb begin
        carry_eff = cflag_i & ~sow_i;
        shin_eff  = sflag_i & ~sow_i;
        masked    = data_i & ~low_i;
        low_shr   = {shin_eff, low_i[BYTE_W-1:1]};
        sflag_nxt_o = 1'b0;
        case (func_i)
            FN_ADD, FN_SHL: begin
                a_op_o = low_i;
                b_op_o = data_i;
                cin_o  = carry_eff;
            end
            FN_BIC: begin
                a_op_o = '0;
                b_op_o = masked;
                cin_o  = 1'b0;
            end
            FN_BIS: begin
                a_op_o = low_i;
                b_op_o = masked;
                cin_o  = 1'b0;
            end
            FN_SHR: begin
                a_op_o = low_shr;
                b_op_o = data_i;
                cin_o  = 1'b0;
                sflag_nxt_o = low_i[0];
            end
            default: begin
                a_op_o = '0;
                b_op_o = data_i;
                cin_o  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bsalu_adder.sv
module bsalu_adder #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] a_i,
    input  logic [BYTE_W-1:0] b_i,
    input  logic              cin_i,
    output logic [BYTE_W-1:0] sum_o,
    output logic              cout_o
);
    logic [BYTE_W:0] chain;

    assign chain[0] = cin_i;

    for (genvar gi = 0; gi < BYTE_W; gi++) begin : g_fa
        assign sum_o[gi]     = a_i[gi] ^ b_i[gi] ^ chain[gi];
        assign chain[gi + 1] = (a_i[gi] & b_i[gi]) | (chain[gi] & (a_i[gi] ^ b_i[gi]));
    end

    assign cout_o = chain[BYTE_W];
endmodule

// File: rtl/bsalu.sv
module bsalu
    import bsalu_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       step_i,
    input  logic                       sow_i,
    input  logic [FUNC_W-1:0]          func_i,
    input  logic [BYTE_W-1:0]          data_i,
    output logic [BYTE_W*NBYTES-1:0]   acc_o,
    output logic                       carry_o
);
    localparam int ACC_W = BYTE_W * NBYTES;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             cf;
        logic             sf;
    } state_t;

    state_t st_d, st_q;

    logic [BYTE_W-1:0] a_op, b_op, sum;
    logic              cin, cout, sflag_nxt;

    bsalu_opgate #(.BYTE_W(BYTE_W)) u_gate (
        .func_i      (func_i),
        .low_i       (st_q.acc[BYTE_W-1:0]),
        .data_i      (data_i),
        .cflag_i     (st_q.cf),
        .sflag_i     (st_q.sf),
        .sow_i       (sow_i),
        .a_op_o      (a_op),
        .b_op_o      (b_op),
        .cin_o       (cin),
        .sflag_nxt_o (sflag_nxt)
    );

    bsalu_adder #(.BYTE_W(BYTE_W)) u_add (
        .a_i    (a_op),
        .b_i    (b_op),
        .cin_i  (cin),
        .sum_o  (sum),
        .cout_o (cout)
    );

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            for (int k = 0; k < NBYTES - 1; k++) begin
                st_d.acc[k*BYTE_W +: BYTE_W] = st_q.acc[(k+1)*BYTE_W +: BYTE_W];
            end
            st_d.acc[ACC_W-1 -: BYTE_W] = sum;
            st_d.cf = cout;
            st_d.sf = sflag_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o   = st_q.acc;
    assign carry_o = st_q.cf;
endmodule

// File: rtl/bsalu_chk.sv
module bsalu_chk
    import bsalu_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     step_i,
    input logic                     sow_i,
    input logic [FUNC_W-1:0]        func_i,
    input logic [BYTE_W-1:0]        data_i,
    input logic [BYTE_W*NBYTES-1:0] acc_o,
    input logic                     carry_o
);
    localparam int ACC_W = BYTE_W * NBYTES;

    logic [BYTE_W-1:0] low, bic_v, add_nc;
    assign low    = acc_o[BYTE_W-1:0];
    assign bic_v  = data_i & ~low;
    assign add_nc = data_i + low;

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(acc_o) && $stable(carry_o));

    if (NBYTES > 1) begin : g_rot
        a_r3_rotate: assert property (@(posedge clk) disable iff (!rst_n)
            step_i |=> acc_o[ACC_W-BYTE_W-1:0] == $past(acc_o[ACC_W-1:BYTE_W]));
    end

    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && func_i == FN_LOAD |=> acc_o[ACC_W-1 -: BYTE_W] == $past(data_i) && !carry_o);

    a_r7_bic: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && func_i == FN_BIC |=> acc_o[ACC_W-1 -: BYTE_W] == $past(bic_v) && !carry_o);

    a_r8_bis_nocarry: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && func_i == FN_BIS |=> !carry_o);

    a_r11_sow_add: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && sow_i && func_i == FN_ADD |=> acc_o[ACC_W-1 -: BYTE_W] == $past(add_nc));
endmodule

bind bsalu bsalu_chk #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (step_i),
    .sow_i   (sow_i),
    .func_i  (func_i),
    .data_i  (data_i),
    .acc_o   (acc_o),
    .carry_o (carry_o)
);

// File: tb/bsalu_bench.sv
module bsalu_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic        sow_i = 1'b0;
    logic [2:0]  func_i = 3'd0;
    logic [7:0]  data_i = 8'd0;
    logic [15:0] acc_o;
    logic        carry_o;

    int total = 0;
    int bad = 0;

    logic [15:0] m_acc = 16'h0000;
    logic        m_c = 1'b0;
    logic        m_s = 1'b0;

    bsalu u_bsalu (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .sow_i(sow_i),
        .func_i(func_i), .data_i(data_i), .acc_o(acc_o), .carry_o(carry_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic compare(input string tag);
        total++;
        if (acc_o !== m_acc || carry_o !== m_c) begin
            bad++;
            $display("FAIL %s acc=%h carry=%b expected acc=%h carry=%b",
                     tag, acc_o, carry_o, m_acc, m_c);
        end
    endtask

    // one clock: drive at negedge, model after posedge, compare at next negedge
    task automatic cyc(input logic st, input logic sw, input logic [2:0] fn,
                       input logic [7:0] d, input string tag);
        int lo, r, cin, sin;
        step_i = st; sow_i = sw; func_i = fn; data_i = d;
        @(posedge clk);
        if (st) begin
            lo  = int'(m_acc[7:0]);
            cin = (sw || !m_c) ? 0 : 1;
            sin = (sw || !m_s) ? 0 : 1;
            case (fn)
                3'd1, 3'd5: r = int'(d) + lo + cin;
                3'd2:       r = int'(d & ~m_acc[7:0]);
                3'd3:       r = int'(d | m_acc[7:0]);
                3'd4:       r = int'(d) + (lo / 2) + sin * 128;
                default:    r = int'(d);
            endcase
            m_s   = (fn == 3'd4) ? m_acc[0] : 1'b0;
            m_c   = (r > 255);
            m_acc = {r[7:0], m_acc[15:8]};
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        // R4 load a word, low byte first
        cyc(1, 1, 3'd0, 8'hFF, "R4 load low");
        cyc(1, 0, 3'd0, 8'h12, "R4 load high");
        if (acc_o !== 16'h12FF) begin bad++; $display("FAIL R3 word=%h expected 12ff", acc_o); end
        total++;

        // R2 idle cycles with busy inputs
        cyc(0, 1, 3'd1, 8'hAA, "R2 hold");
        cyc(0, 0, 3'd4, 8'h55, "R2 hold");

        // R5 word add 0x12FF + 0x0001 -> 0x1300 with carry between bytes
        cyc(1, 1, 3'd1, 8'h01, "R5 add low carry");
        cyc(1, 0, 3'd1, 8'h00, "R5 add high with cin");
        if (acc_o !== 16'h1300) begin bad++; $display("FAIL R5 sum=%h expected 1300", acc_o); end
        total++;

        // R11 sow clears a held carry
        cyc(1, 1, 3'd0, 8'hF0, "R4 load");
        cyc(1, 0, 3'd0, 8'h80, "R4 load");
        cyc(1, 1, 3'd1, 8'h20, "R5 add makes carry");
        cyc(1, 1, 3'd1, 8'h00, "R11 sow clears carry-in");

        // R6 shift left via add of itself: 0x4081 << 1
        cyc(1, 1, 3'd0, 8'h81, "R4 load");
        cyc(1, 0, 3'd0, 8'h40, "R4 load");
        cyc(1, 1, 3'd5, 8'h81, "R6 shl low");
        cyc(1, 0, 3'd5, 8'h40, "R6 shl high");

        // R7 / R8 bit clear and set
        cyc(1, 1, 3'd2, 8'hFF, "R7 bic");
        cyc(1, 0, 3'd2, 8'h0F, "R7 bic");
        cyc(1, 1, 3'd3, 8'hC3, "R8 bis");
        cyc(1, 0, 3'd3, 8'h18, "R8 bis");

        // R9 shift right: shift-in from previous step
        cyc(1, 1, 3'd0, 8'h03, "R4 load");
        cyc(1, 0, 3'd0, 8'h81, "R4 load");
        cyc(1, 1, 3'd4, 8'h00, "R9 shr first");
        cyc(1, 0, 3'd4, 8'h00, "R9 shr shift-in");
        cyc(1, 1, 3'd4, 8'h00, "R11 sow clears shift-in");
        cyc(1, 0, 3'd4, 8'hF0, "R9 shr adds data");

        // R10 unused codes act as load
        cyc(1, 0, 3'd6, 8'h5A, "R10 code6");
        cyc(1, 0, 3'd7, 8'hA5, "R10 code7");

        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            cyc(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                3'($urandom_range(0, 7)), 8'($urandom_range(0, 255)), "R3 R9 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule